// File: doc/BRIEF.md
# Host Bus Arbiter with DMA Handshake

This block decides who may drive a shared 6502-style host bus when three parties compete for it: the host CPU, a video controller that borrows the bus for its own fetches, and an expansion DMA engine. Everything runs on one fast system clock. The host phase and the host cycle boundaries reach the block as qualifier strobes, and every latch is modelled as an enabled register on that clock.

The raw bus-available line is captured only while the first host phase is active. A saturating counter then watches for the video controller taking the bus for good, and raises a takeover flag after a run of consecutive host cycles with the sampled line low. The internal DMA request is captured on its own phase strobe. It is merged with its live value into the external request, which asserts as soon as either copy is low, so the host CPU is held through its ready input. The enable for the host R/W and address drivers opens only while the bus is available, a DMA request is pending and the first host phase is inactive.

Top module: `host_bus_arbiter`

## Requirements
- R1: While `rst` is high, and on the first edge after it is sampled high, `dma_n_out` becomes 1, `bus_taken` becomes 0 and `drv_en` becomes 0. The captured bus-available copy resets to 1 and the captured request copy resets to 1.
- R2: The captured bus-available copy takes the value of `bus_avail` on an edge where `phi1` is 1 and holds its value on every other edge.
- R3: `bus_taken` is 1 in the cycle after the edge on which the count of consecutive `host_cyc` edges with a low captured bus-available copy reaches TAKE_CYCLES (default 3). Runs of 1 or 2 such cycles leave it at 0.
- R4: A `host_cyc` edge that sees a high captured bus-available copy clears the count, so `bus_taken` is 0 after that edge.
- R5: The count and `bus_taken` change only on edges where `host_cyc` is 1.
- R6: The captured request copy takes `dma_req_n` on an edge where `dma_phase` is 1 and holds otherwise.
- R7: On each edge `dma_n_out` is loaded with the AND of the live `dma_req_n` and the captured request copy held before that edge. A low on either one drives it low (0 = request active).
- R8: On each edge `drv_en` is loaded with 1 exactly when the captured bus-available copy held before that edge is 1, `dma_req_n` is 0 and `phi1` is 0.
- R9: The count saturates at TAKE_CYCLES, so `bus_taken` stays 1 through a low run of any length, 20 cycles included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_avail | input | 1 | Raw bus-available line from the video controller (1 = CPU may use bus) |
| dma_req_n | input | 1 | Internal DMA request, active low |
| phi1 | input | 1 | Qualifier, 1 while the first host phase is active |
| host_cyc | input | 1 | One-clock strobe per host cycle |
| dma_phase | input | 1 | Phase strobe that captures the DMA request |
| dma_n_out | output | 1 | External DMA request to the host, active low |
| bus_taken | output | 1 | 1 when the video controller owns the bus completely |
| drv_en | output | 1 | Enable for the host R/W and address drivers |

## Verification
Directed bus-available low runs of 1, 2, 3 and 5 host cycles separate a correct threshold from an off-by-one counter. A 20-cycle run exposes a counter that wraps instead of saturating. A low run with no host cycle strobes shows whether the count keeps to host cycles or counts raw clocks. Long random mixes of phase, strobe and request patterns, compared every cycle against a bench model, tell apart the AND merge of the live and captured request from either copy used alone, and show whether the driver enable respects the phase gate.

// File: rtl/hba_pkg.sv
package hba_pkg;
  // Width of a saturating counter able to hold the value lim.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/hba_phase_latch.sv
// Enabled register standing in for a transparent phase latch.
module hba_phase_latch #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end

  AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R6
endmodule

// File: rtl/hba_takeover_cnt.sv
// Counts consecutive host cycles with the sampled bus-available line low.
module hba_takeover_cnt #(
  parameter int TAKE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic host_cyc,
  input  logic ba_s,
  output logic taken
);
  localparam int CW = hba_pkg::cnt_width(TAKE_CYCLES);
  localparam logic [CW-1:0] LIM = CW'(TAKE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (host_cyc) begin
      if (ba_s)             cnt_d = '0;
      else if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      taken <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      taken <= (cnt_d >= LIM);
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM); // R9
  AST_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    host_cyc && ba_s |=> !taken); // R4
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_cyc |=> $stable(cnt_q) && $stable(taken)); // R5
  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(taken) |-> $past(!ba_s && host_cyc)); // R3
endmodule

// File: rtl/hba_dma_merge.sv
// External request: live request ANDed with its phase-captured copy.
module hba_dma_merge (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic req_lat_n,
  output logic dma_n
);
  always_ff @(posedge clk) begin
    if (rst) dma_n <= 1'b1;
    else     dma_n <= req_n & req_lat_n;
  end

  AST_RELEASE_BOTH_HIGH: assert property (@(posedge clk) disable iff (rst)
    req_n && req_lat_n |=> dma_n); // R7
  AST_ASSERT_LIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    !req_n |=> !dma_n); // R7
endmodule

// File: rtl/hba_drv_enable.sv
// Host R/W and address driver enable.
module hba_drv_enable (
  input  logic clk,
  input  logic rst,
  input  logic ba_s,
  input  logic req_n,
  input  logic phi1,
  output logic drv_en
);
  always_ff @(posedge clk) begin
    if (rst) drv_en <= 1'b0;
    else     drv_en <= ba_s & ~req_n & ~phi1;
  end

  AST_OFF_IN_PHI1: assert property (@(posedge clk) disable iff (rst)
    phi1 |=> !drv_en); // R8
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    req_n |=> !drv_en); // R8
endmodule

// File: rtl/host_bus_arbiter.sv
module host_bus_arbiter #(
  parameter int TAKE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_avail,
  input  logic dma_req_n,
  input  logic phi1,
  input  logic host_cyc,
  input  logic dma_phase,
  output logic dma_n_out,
  output logic bus_taken,
  output logic drv_en
);
  logic ba_s;
  logic req_lat_n;

  hba_phase_latch #(.W(1), .RST_VAL(1'b1)) u_ba_lat (
    .clk(clk), .rst(rst), .en(phi1), .d(bus_avail), .q(ba_s));

  hba_phase_latch #(.W(1), .RST_VAL(1'b1)) u_req_lat (
    .clk(clk), .rst(rst), .en(dma_phase), .d(dma_req_n), .q(req_lat_n));

  hba_takeover_cnt #(.TAKE_CYCLES(TAKE_CYCLES)) u_take (
    .clk(clk), .rst(rst), .host_cyc(host_cyc), .ba_s(ba_s), .taken(bus_taken));

  hba_dma_merge u_merge (
    .clk(clk), .rst(rst), .req_n(dma_req_n), .req_lat_n(req_lat_n),
    .dma_n(dma_n_out));

  hba_drv_enable u_drv (
    .clk(clk), .rst(rst), .ba_s(ba_s), .req_n(dma_req_n), .phi1(phi1),
    .drv_en(drv_en));

  AST_BA_FOLLOWS_PHI1: assert property (@(posedge clk) disable iff (rst)
    phi1 |=> ba_s == $past(bus_avail)); // R2
  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> dma_n_out && !drv_en && !bus_taken); // R1
endmodule

// File: tb/host_bus_arbiter_tb.sv
`timescale 1ns/1ps
module host_bus_arbiter_tb;
  localparam int TAKE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_avail = 1'b1, dma_req_n = 1'b1, phi1 = 1'b0, host_cyc = 1'b0, dma_phase = 1'b0;
  logic dma_n_out, bus_taken, drv_en;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_bus_arbiter #(.TAKE_CYCLES(TAKE)) u_dut (
    .clk(clk), .rst(rst), .bus_avail(bus_avail), .dma_req_n(dma_req_n),
    .phi1(phi1), .host_cyc(host_cyc), .dma_phase(dma_phase),
    .dma_n_out(dma_n_out), .bus_taken(bus_taken), .drv_en(drv_en));

  // Bench model built from the requirements.
  logic m_ba = 1'b1, m_rl = 1'b1, m_take = 1'b0, m_dma = 1'b1, m_drv = 1'b0;
  int m_cnt = 0;

  function automatic int next_cnt(int c, bit strobe, bit ba);
    if (!strobe) return c;
    if (ba) return 0;
    return (c < TAKE) ? c + 1 : c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ba <= 1'b1; m_rl <= 1'b1; m_cnt <= 0;
      m_take <= 1'b0; m_dma <= 1'b1; m_drv <= 1'b0;
    end else begin
      if (phi1) m_ba <= bus_avail;                       // R2
      if (dma_phase) m_rl <= dma_req_n;                  // R6
      m_cnt  <= next_cnt(m_cnt, host_cyc, m_ba);
      m_take <= next_cnt(m_cnt, host_cyc, m_ba) >= TAKE; // R3 R4 R5 R9
      m_dma  <= dma_req_n & m_rl;                        // R7
      m_drv  <= m_ba & ~dma_req_n & ~phi1;               // R8
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model();
    chk("R7 dma_n_out", dma_n_out, m_dma);
    chk("R8 drv_en", drv_en, m_drv);
    chk("R3 bus_taken", bus_taken, m_take);
  endtask

  // One cycle: drive at the falling edge, compare after the next rising edge.
  task automatic step(input bit ba, input bit req, input bit p1, input bit hc, input bit dp);
    bus_avail = ba; dma_req_n = req; phi1 = p1; host_cyc = hc; dma_phase = dp;
    @(negedge clk);
    check_model();
  endtask

  // Low run of n host cycles; reports whether bus_taken was seen high.
  task automatic ba_run(input int n, input bit strobe, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0);
    for (int i = 0; i < n; i++) begin
      step(0, 1, 1, strobe, 0);
      if (bus_taken) seen = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 1, strobe, 0);
      if (bus_taken) seen = 1'b1;
    end
  endtask

  initial begin
    bit seen;
    void'($urandom(32'd4711));
    @(negedge clk);
    @(negedge clk);
    chk("R1 dma_n_out reset", dma_n_out, 1'b1);
    chk("R1 drv_en reset", drv_en, 1'b0);
    chk("R1 bus_taken reset", bus_taken, 1'b0);
    rst = 1'b0;

    // Run lengths 1, 2, 3 and 5.
    ba_run(1, 1, seen); chk("R3 run1 no takeover", seen, 1'b0);
    ba_run(2, 1, seen); chk("R3 run2 no takeover", seen, 1'b0);
    ba_run(3, 1, seen); chk("R3 run3 takeover", seen, 1'b1);
    chk("R4 cleared after high", bus_taken, 1'b0);
    ba_run(5, 1, seen); chk("R3 run5 takeover", seen, 1'b1);
    // No host cycle strobes: no counting.
    ba_run(6, 0, seen); chk("R5 no strobe no takeover", seen, 1'b0);

    // Saturation over a long run.
    for (int i = 0; i < 20; i++) step(0, 1, 1, 1, 0);
    chk("R9 held after 20 cycles", bus_taken, 1'b1);
    step(0, 1, 1, 1, 0);
    chk("R9 no wrap", bus_taken, 1'b1);
    step(1, 1, 1, 1, 0);
    step(1, 1, 1, 1, 0);
    chk("R4 cleared after long run", bus_taken, 1'b0);

    // Phase gate on the bus-available capture, seen through drv_en.
    step(1, 0, 0, 0, 0);
    chk("R8 drv_en opens", drv_en, 1'b1);
    step(0, 0, 0, 0, 0);
    chk("R2 closed phase ignores low", drv_en, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R8 phi1 closes enable", drv_en, 1'b0);
    step(1, 0, 0, 0, 0);
    chk("R2 captured low blocks enable", drv_en, 1'b0);

    // Request capture and merge.
    step(1, 0, 0, 0, 1);
    chk("R7 live low asserts", dma_n_out, 1'b0);
    step(1, 1, 0, 0, 0);
    chk("R6 R7 captured low holds request", dma_n_out, 1'b0);
    step(1, 1, 0, 0, 1);
    step(1, 1, 0, 0, 0);
    chk("R6 R7 recapture releases", dma_n_out, 1'b1);

    // Random mix.
    for (int i = 0; i < 4000; i++) begin
      logic b;
      b = ($urandom % 4 == 0) ? ~bus_avail : bus_avail;
      step(b, ($urandom % 3 != 0), $urandom % 2, $urandom % 2, ($urandom % 4 == 0));
    end

    // Reset mid-operation.
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 1);
    rst = 1'b1;
    step(0, 0, 0, 1, 1);
    chk("R1 dma_n_out after reset", dma_n_out, 1'b1);
    chk("R1 bus_taken after reset", bus_taken, 1'b0);
    chk("R1 drv_en after reset", drv_en, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule